// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Selector

This block holds an age-ordered queue of DRAM requests and decides which one a memory controller should issue next. Each slot carries a bank number, a row address and a payload. Slot 0 is the oldest entry and is the head of the queue. The controller supplies the live per-bank state as inputs: the row held open in each bank, a flag that says whether a row is open, and the time at which each bank becomes free. It also supplies the current time.

When the policy input selects plain first-come-first-served, the head is always the choice. When it selects reordering, the block scans from oldest to youngest. A request that hits the open row of its bank wins over everything else. If there is no hit, the oldest request whose bank is ready wins. A bank counts as ready if its free time has already arrived, or if it is among the banks that will become free earliest, taking only the banks that queued requests refer to. When the issue strobe is applied, the chosen entry moves to the head. All other entries keep their relative age order.

The same block serves a read queue or a write queue. The controller fills the queue with a push strobe and retires the head with a pop strobe.

Top module: `rf_sched_select`

## Requirements
- R1: After reset the occupancy is 0 and `sel_valid` is low. An empty queue never asserts `sel_valid`.
- R2: A push appends the entry at the tail (slot index = occupancy). The head outputs always show slot 0. A push to a full queue (occupancy = DEPTH) is ignored.
- R3: A pop removes slot 0. Every remaining entry moves down one slot in the same order, and occupancy drops by one.
- R4: With `reorder_en` low, `sel_idx` is 0 and `sel_hit` is 0, whatever row hits exist.
- R5: With `reorder_en` high, the oldest valid entry whose row equals the open row of its bank is selected, and `sel_hit` is 1. This holds even when an older entry has a ready bank.
- R6: An entry whose bank has `bank_row_open` low is never a row hit, even if the row fields match.
- R7: If there is no row hit, a non-hit entry is ready when its bank's free time is at or before `now_time`. The oldest ready entry is selected, and younger ready entries do not displace it.
- R8: A bank is also ready if its free time equals the minimum free time taken over the banks referenced by valid entries. Banks that no valid entry references do not take part in that minimum.
- R9: An issue strobe with a valid selection moves the selected entry to slot 0. Entries that were older than it each shift up one slot, and younger entries stay where they are. `promote_fire` is high in that cycle when the selected index is not 0.
- R10: Only one queue operation takes effect per cycle. Issue takes priority over pop, and pop takes priority over push. A strobe that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reorder_en | input | 1 | 0 selects first-come-first-served, 1 selects row-hit-first reordering |
| push | input | 1 | Append a request at the tail |
| push_bank | input | BANK_W | Bank number of the pushed request |
| push_row | input | ROW_W | Row address of the pushed request |
| push_data | input | PAY_W | Payload of the pushed request |
| pop | input | 1 | Remove the head entry |
| issue | input | 1 | Move the selected entry to the head |
| bank_open_row | input | NBANK*ROW_W | Open row of each bank, bank b at bits [b*ROW_W +: ROW_W] |
| bank_row_open | input | NBANK | One bit per bank: a row is open |
| bank_free_at | input | NBANK*TS_W | Free time of each bank, bank b at bits [b*TS_W +: TS_W] |
| now_time | input | TS_W | Current time |
| sel_valid | output | 1 | Queue is non-empty, so a selection exists |
| sel_idx | output | IDX_W | Slot index of the selected entry |
| sel_hit | output | 1 | The selection is a row hit |
| promote_fire | output | 1 | The issue strobe will move a non-head entry this cycle |
| head_bank | output | BANK_W | Bank number of slot 0 |
| head_row | output | ROW_W | Row address of slot 0 |
| head_data | output | PAY_W | Payload of slot 0 |
| occupancy | output | CNT_W | Number of valid entries |

## Verification
The bench builds the block with a four-entry queue, four banks, 8-bit rows, 16-bit times and 8-bit payloads. With only four slots, the queue reaches the full state quickly, so the dropped push can be checked. The same size still leaves room for an older ready entry, a hit and a younger hit to share the queue, and for a referenced bank and an unreferenced bank to compete for the earliest free time. After each promotion, a chain of pops reads the whole queue back through the head outputs, which shows that the age order survived the move.

// File: rtl/rf_sched_pkg.sv
package rf_sched_pkg;
  // One queue operation per cycle, decoded at the top level
  typedef enum logic [1:0] {
    Q_IDLE    = 2'd0,
    Q_PROMOTE = 2'd1,
    Q_POP     = 2'd2,
    Q_PUSH    = 2'd3
  } q_op_e;
endpackage

// File: rtl/rf_age_queue.sv
module rf_age_queue
  import rf_sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int PAY_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  q_op_e                         op,
  input  logic [IDX_W-1:0]              sel_idx,
  input  logic [BANK_W-1:0]             in_bank,
  input  logic [ROW_W-1:0]              in_row,
  input  logic [PAY_W-1:0]              in_pay,
  output logic [DEPTH-1:0]              q_valid,
  output logic [DEPTH-1:0][BANK_W-1:0]  q_bank,
  output logic [DEPTH-1:0][ROW_W-1:0]   q_row,
  output logic [DEPTH-1:0][PAY_W-1:0]   q_pay,
  output logic [CNT_W-1:0]              count
);

  logic [DEPTH-1:0][BANK_W-1:0] bank_r;
  logic [DEPTH-1:0][ROW_W-1:0]  row_r;
  logic [DEPTH-1:0][PAY_W-1:0]  pay_r;
  logic [CNT_W-1:0]             cnt_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      bank_r <= '0;
      row_r  <= '0;
      pay_r  <= '0;
    end else begin
      unique case (op)
        Q_PROMOTE: begin
          // selected entry to slot 0, older ones shift up by one
          for (int i = 0; i < DEPTH; i++) begin
            if (i == 0) begin
              bank_r[0] <= bank_r[sel_idx];
              row_r[0]  <= row_r[sel_idx];
              pay_r[0]  <= pay_r[sel_idx];
            end else if (IDX_W'(i) <= sel_idx) begin
              bank_r[i] <= bank_r[i-1];
              row_r[i]  <= row_r[i-1];
              pay_r[i]  <= pay_r[i-1];
            end
          end
        end
        Q_POP: begin
          for (int i = 0; i < DEPTH - 1; i++) begin
            bank_r[i] <= bank_r[i+1];
            row_r[i]  <= row_r[i+1];
            pay_r[i]  <= pay_r[i+1];
          end
          cnt_r <= cnt_r - CNT_W'(1);
        end
        Q_PUSH: begin
          bank_r[cnt_r[IDX_W-1:0]] <= in_bank;
          row_r[cnt_r[IDX_W-1:0]]  <= in_row;
          pay_r[cnt_r[IDX_W-1:0]]  <= in_pay;
          cnt_r <= cnt_r + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) q_valid[i] = (CNT_W'(i) < cnt_r);
  end

  assign q_bank = bank_r;
  assign q_row  = row_r;
  assign q_pay  = pay_r;
  assign count  = cnt_r;

  // R9
  promote_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == Q_PROMOTE |=> q_pay[0] == $past(q_pay[sel_idx]));

  // R3
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == Q_POP |=> $past(count) == count + CNT_W'(1));

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/rf_early_mask.sv
module rf_early_mask #(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 8,
  parameter int TS_W   = 32,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              q_valid,
  input  logic [DEPTH-1:0][BANK_W-1:0]  q_bank,
  input  logic [NBANK*TS_W-1:0]         bank_free_at,
  output logic [NBANK-1:0]              early_mask
);

  function automatic logic [TS_W-1:0] free_of(input logic [NBANK*TS_W-1:0] v, input int b);
    return v[b*TS_W +: TS_W];
  endfunction

  logic [NBANK-1:0] bank_used;
  logic [TS_W-1:0]  min_free;

  always_comb begin
    bank_used = '0;
    min_free  = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_valid[i]) begin
        bank_used[q_bank[i]] = 1'b1;
        if (free_of(bank_free_at, int'(q_bank[i])) < min_free)
          min_free = free_of(bank_free_at, int'(q_bank[i]));
      end
    end
    for (int b = 0; b < NBANK; b++)
      early_mask[b] = bank_used[b] && (free_of(bank_free_at, b) == min_free);
  end

  // R8
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_valid) |-> (|early_mask));

endmodule

// File: rtl/rf_pick.sv
module rf_pick #(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 8,
  parameter int ROW_W  = 14,
  parameter int TS_W   = 32,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reorder_en,
  input  logic [DEPTH-1:0]              q_valid,
  input  logic [DEPTH-1:0][BANK_W-1:0]  q_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]   q_row,
  input  logic [NBANK*ROW_W-1:0]        bank_open_row,
  input  logic [NBANK-1:0]              bank_row_open,
  input  logic [NBANK*TS_W-1:0]         bank_free_at,
  input  logic [TS_W-1:0]               now_time,
  input  logic [NBANK-1:0]              early_mask,
  output logic [IDX_W-1:0]              sel_idx,
  output logic                          sel_valid,
  output logic                          sel_hit
);

  function automatic logic row_hit(input logic is_open, input logic [ROW_W-1:0] open_row,
                                   input logic [ROW_W-1:0] row);
    return is_open && (open_row == row);
  endfunction

  function automatic logic bank_ready(input logic [TS_W-1:0] free_t, input logic [TS_W-1:0] now_t,
                                      input logic earliest);
    return (free_t <= now_t) || earliest;
  endfunction

  logic [DEPTH-1:0] entry_hit, entry_rdy;
  logic             hit_seen, rdy_seen;
  logic [IDX_W-1:0] hit_idx, rdy_idx;

  always_comb begin
    hit_seen = 1'b0;
    rdy_seen = 1'b0;
    hit_idx  = '0;
    rdy_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      entry_hit[i] = q_valid[i] &&
        row_hit(bank_row_open[q_bank[i]], bank_open_row[int'(q_bank[i])*ROW_W +: ROW_W], q_row[i]);
      entry_rdy[i] = q_valid[i] && !entry_hit[i] &&
        bank_ready(bank_free_at[int'(q_bank[i])*TS_W +: TS_W], now_time, early_mask[q_bank[i]]);
      if (entry_hit[i] && !hit_seen) begin
        hit_seen = 1'b1;
        hit_idx  = IDX_W'(i);
      end
      if (entry_rdy[i] && !rdy_seen) begin
        rdy_seen = 1'b1;
        rdy_idx  = IDX_W'(i);
      end
    end
    sel_valid = q_valid[0];
    sel_hit   = reorder_en && hit_seen;
    if (!reorder_en)   sel_idx = '0;
    else if (hit_seen) sel_idx = hit_idx;
    else if (rdy_seen) sel_idx = rdy_idx;
    else               sel_idx = '0;
  end

  // R4
  fcfs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reorder_en |-> (sel_idx == '0 && !sel_hit));

  // R6
  hit_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> bank_row_open[q_bank[sel_idx]]);

  // R5
  hit_row_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> q_row[sel_idx] == bank_open_row[int'(q_bank[sel_idx])*ROW_W +: ROW_W]);

  // R1
  sel_points_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> q_valid[sel_idx]);

endmodule

// File: rtl/rf_sched_select.sv
module rf_sched_select
  import rf_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NBANK = 8,
  parameter int ROW_W = 14,
  parameter int TS_W  = 32,
  parameter int PAY_W = 16,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reorder_en,
  input  logic                    push,
  input  logic [BANK_W-1:0]       push_bank,
  input  logic [ROW_W-1:0]        push_row,
  input  logic [PAY_W-1:0]        push_data,
  input  logic                    pop,
  input  logic                    issue,
  input  logic [NBANK*ROW_W-1:0]  bank_open_row,
  input  logic [NBANK-1:0]        bank_row_open,
  input  logic [NBANK*TS_W-1:0]   bank_free_at,
  input  logic [TS_W-1:0]         now_time,
  output logic                    sel_valid,
  output logic [IDX_W-1:0]        sel_idx,
  output logic                    sel_hit,
  output logic                    promote_fire,
  output logic [BANK_W-1:0]       head_bank,
  output logic [ROW_W-1:0]        head_row,
  output logic [PAY_W-1:0]        head_data,
  output logic [CNT_W-1:0]        occupancy
);

  logic [DEPTH-1:0]             q_valid;
  logic [DEPTH-1:0][BANK_W-1:0] q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  q_row;
  logic [DEPTH-1:0][PAY_W-1:0]  q_pay;
  logic [NBANK-1:0]             early_mask;
  q_op_e                        op;

  // issue beats pop, pop beats push
  always_comb begin
    if (issue && sel_valid)                       op = Q_PROMOTE;
    else if (pop && occupancy != '0)              op = Q_POP;
    else if (push && occupancy != CNT_W'(DEPTH))  op = Q_PUSH;
    else                                          op = Q_IDLE;
  end

  rf_age_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .PAY_W(PAY_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .op(op), .sel_idx(sel_idx),
    .in_bank(push_bank), .in_row(push_row), .in_pay(push_data),
    .q_valid(q_valid), .q_bank(q_bank), .q_row(q_row), .q_pay(q_pay), .count(occupancy)
  );

  rf_early_mask #(.DEPTH(DEPTH), .NBANK(NBANK), .TS_W(TS_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_bank(q_bank),
    .bank_free_at(bank_free_at), .early_mask(early_mask)
  );

  rf_pick #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .TS_W(TS_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .reorder_en(reorder_en),
    .q_valid(q_valid), .q_bank(q_bank), .q_row(q_row),
    .bank_open_row(bank_open_row), .bank_row_open(bank_row_open),
    .bank_free_at(bank_free_at), .now_time(now_time), .early_mask(early_mask),
    .sel_idx(sel_idx), .sel_valid(sel_valid), .sel_hit(sel_hit)
  );

  assign promote_fire = (op == Q_PROMOTE) && (sel_idx != '0);
  assign head_bank    = q_bank[0];
  assign head_row     = q_row[0];
  assign head_data    = q_pay[0];

  // R1
  empty_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy == '0 |-> !sel_valid);

  // R10
  issue_blocks_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && sel_valid) |=> occupancy == $past(occupancy));

endmodule

// File: tb/tb_rf_sched_select.sv
module tb_rf_sched_select;
  localparam int DEPTH = 4, NBANK = 4, ROW_W = 8, TS_W = 16, PAY_W = 8;
  localparam int BANK_W = $clog2(NBANK), IDX_W = $clog2(DEPTH), CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reorder_en = 1'b0, push = 1'b0, pop = 1'b0, issue = 1'b0;
  logic [BANK_W-1:0] push_bank = '0;
  logic [ROW_W-1:0]  push_row = '0;
  logic [PAY_W-1:0]  push_data = '0;
  logic [NBANK*ROW_W-1:0] bank_open_row = '0;
  logic [NBANK-1:0]       bank_row_open = '0;
  logic [NBANK*TS_W-1:0]  bank_free_at = '0;
  logic [TS_W-1:0]        now_time = '0;
  logic sel_valid, sel_hit, promote_fire;
  logic [IDX_W-1:0]  sel_idx;
  logic [BANK_W-1:0] head_bank;
  logic [ROW_W-1:0]  head_row;
  logic [PAY_W-1:0]  head_data;
  logic [CNT_W-1:0]  occupancy;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rf_sched_select #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .TS_W(TS_W), .PAY_W(PAY_W)) dut (
    .clk(clk), .rst_n(rst_n), .reorder_en(reorder_en), .push(push), .push_bank(push_bank),
    .push_row(push_row), .push_data(push_data), .pop(pop), .issue(issue),
    .bank_open_row(bank_open_row), .bank_row_open(bank_row_open), .bank_free_at(bank_free_at),
    .now_time(now_time), .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_hit(sel_hit),
    .promote_fire(promote_fire), .head_bank(head_bank), .head_row(head_row),
    .head_data(head_data), .occupancy(occupancy)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic set_bank(input int b, input bit open, input int row, input int free_t);
    bank_row_open[b] = open;
    bank_open_row[b*ROW_W +: ROW_W] = ROW_W'(row);
    bank_free_at[b*TS_W +: TS_W] = TS_W'(free_t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push = 0; pop = 0; issue = 0; reorder_en = 0; now_time = '0;
    for (int b = 0; b < NBANK; b++) set_bank(b, 1'b0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push_e(input int b, input int r, input int d);
    @(negedge clk);
    push = 1'b1; push_bank = BANK_W'(b); push_row = ROW_W'(r); push_data = PAY_W'(d);
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic pop_e();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic issue_e();
    @(negedge clk); issue = 1'b1;
    @(negedge clk); issue = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 occupancy after reset", int'(occupancy), 0);
    chk("R1 sel_valid on empty queue", int'(sel_valid), 0);
  endtask

  task automatic t_fcfs_fill();
    do_reset();
    set_bank(2, 1'b1, 3, 0);
    push_e(0, 1, 10); push_e(1, 2, 11); push_e(2, 3, 12); push_e(3, 4, 13);
    chk("R2 occupancy full", int'(occupancy), 4);
    chk("R4 fcfs sel_idx", int'(sel_idx), 0);
    chk("R4 fcfs sel_hit", int'(sel_hit), 0);
    push_e(1, 9, 99);
    chk("R2 push on full dropped", int'(occupancy), 4);
    chk("R2 head unchanged", int'(head_data), 10);
    issue_e();
    chk("R4 fcfs issue keeps head", int'(head_data), 10);
  endtask

  task automatic t_hit_first();
    do_reset();
    reorder_en = 1'b1; now_time = 16'd10;
    set_bank(0, 1'b0, 0, 0);
    set_bank(1, 1'b1, 9, 0);
    set_bank(2, 1'b1, 9, 0);
    push_e(0, 1, 20); push_e(1, 2, 21); push_e(1, 9, 22); push_e(2, 9, 23);
    chk("R5 oldest hit beats older ready", int'(sel_idx), 2);
    chk("R5 sel_hit", int'(sel_hit), 1);
    @(negedge clk); issue = 1'b1;
    #1 chk("R9 promote_fire", int'(promote_fire), 1);
    @(negedge clk); issue = 1'b0;
    chk("R9 promoted to head", int'(head_data), 22);
    chk("R9 occupancy kept", int'(occupancy), 4);
    chk("R5 head hit now selected", int'(sel_idx), 0);
    pop_e();
    chk("R3 R9 order after pop 1", int'(head_data), 20);
    chk("R5 younger hit after pop", int'(sel_idx), 2);
    pop_e();
    chk("R3 order after pop 2", int'(head_data), 21);
    pop_e();
    chk("R3 order after pop 3", int'(head_data), 23);
    chk("R3 occupancy after pops", int'(occupancy), 1);
  endtask

  task automatic t_closed_bank();
    do_reset();
    reorder_en = 1'b1; now_time = '0;
    set_bank(0, 1'b0, 5, 30);
    set_bank(1, 1'b0, 0, 10);
    push_e(0, 5, 30); push_e(1, 7, 31);
    chk("R6 closed bank no hit", int'(sel_hit), 0);
    chk("R6 closed bank falls to earliest", int'(sel_idx), 1);
  endtask

  task automatic t_earliest();
    do_reset();
    reorder_en = 1'b1; now_time = '0;
    set_bank(0, 1'b0, 0, 50);
    set_bank(1, 1'b0, 0, 20);
    set_bank(2, 1'b0, 0, 5);
    set_bank(3, 1'b0, 0, 20);
    push_e(0, 1, 40); push_e(3, 1, 41); push_e(1, 1, 42);
    chk("R8 earliest over referenced banks", int'(sel_idx), 1);
    issue_e();
    chk("R8 earliest entry promoted", int'(head_data), 41);
  endtask

  task automatic t_ready_now();
    do_reset();
    reorder_en = 1'b1; now_time = 16'd100;
    set_bank(0, 1'b0, 0, 120);
    set_bank(1, 1'b0, 0, 80);
    set_bank(2, 1'b0, 0, 40);
    push_e(0, 1, 50); push_e(1, 1, 51); push_e(2, 1, 52);
    chk("R7 oldest free-now entry", int'(sel_idx), 1);
    chk("R7 no hit flagged", int'(sel_hit), 0);
  endtask

  task automatic t_priority();
    do_reset();
    reorder_en = 1'b1;
    push_e(0, 1, 60); push_e(1, 2, 61);
    @(negedge clk);
    push = 1'b1; pop = 1'b1; push_bank = '0; push_row = '0; push_data = 8'd62;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    chk("R10 pop beats push occupancy", int'(occupancy), 1);
    chk("R10 pop beats push head", int'(head_data), 61);
    push_e(2, 3, 63);
    set_bank(2, 1'b1, 3, 0);
    @(negedge clk);
    issue = 1'b1; pop = 1'b1;
    @(negedge clk);
    issue = 1'b0; pop = 1'b0;
    chk("R10 issue beats pop occupancy", int'(occupancy), 2);
    chk("R10 issue beats pop head", int'(head_data), 63);
  endtask

  initial begin
    t_reset();
    t_fcfs_fill();
    t_hit_first();
    t_closed_bank();
    t_earliest();
    t_ready_now();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule